// File: doc/BRIEF.md
# Configuration Data Window Bridge

This block sits between a host register port and a downstream configuration bus. The host first programs a 32-bit configuration address into an address register. It then reads or writes a small data window, and each such access turns into one downstream configuration transaction. The top bit of the stored address acts as an enable. While that bit is clear, data-window writes are dropped and data-window reads return all-ones at the access width, so probing a missing function gives the usual "nothing there" pattern.

The two low host address bits act as a byte offset. They are ORed into the downstream address for every access except full-word writes, which use the stored address unchanged. A build parameter selects big-endian host byte order. In that mode, halfword and word data are byte-swapped on the way down and on the way back. Only one downstream transaction is outstanding at a time. The host sees `host_ready` low until the downstream side answers with `dn_done`.

Top module: `cfg_data_bridge`

## Requirements
- R1: After a synchronous active-low reset, the stored configuration address is 0 (window disabled), `dn_req` and `host_rvalid` are 0 and `host_ready` is 1.
- R2: An accepted write with `host_sel`=1 loads all 32 bits of `host_wdata` into the address register. An accepted read with `host_sel`=1 returns the stored value one cycle later, with `host_rvalid` high for one cycle.
- R3: A data-window write (`host_sel`=0) while address bit 31 is clear issues no downstream request.
- R4: A data-window read while bit 31 is clear issues no downstream request. It returns, one cycle after acceptance, 0x000000FF for a byte, 0x0000FFFF for a halfword and 0xFFFFFFFF for a word.
- R5: With bit 31 set, byte writes, halfword writes and reads of any size present `dn_addr` = stored address OR `host_ofs`.
- R6: With bit 31 set, a word write presents `dn_addr` equal to the stored address, with `host_ofs` ignored.
- R7: `host_size` encodes 0=byte, 1=halfword, 2=word and 3=word. `dn_bytes` carries 1, 2 or 4 to match, and `dn_we` is 1 exactly for writes.
- R8: Downstream write data is the low 1, 2 or 4 bytes of `host_wdata`, zero-extended. With BIG_ENDIAN=1, halfword and word write data have their byte order reversed. Byte data is never reversed.
- R9: Host read data is the low 1, 2 or 4 bytes of `dn_rdata`, zero-extended, and returned with `host_rvalid` in the cycle after `dn_done`. With BIG_ENDIAN=1, halfword and word results have their byte order reversed. Byte results are never reversed.
- R10: `dn_req` stays high from acceptance until the cycle after `dn_done`. `host_ready` is low for that whole span, and host strobes given while `host_ready` is low are ignored. When `host_rd` and `host_wr` are both high, the write is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 1 | 1 selects the address register, 0 the data window |
| host_ofs | input | 2 | Low host address bits (byte offset) |
| host_size | input | 2 | Access size: 0 byte, 1 halfword, 2 or 3 word |
| host_rd | input | 1 | Read strobe, taken when host_ready is high |
| host_wr | input | 1 | Write strobe, taken when host_ready is high |
| host_wdata | input | 32 | Host write data |
| host_ready | output | 1 | High when a new access can be accepted |
| host_rvalid | output | 1 | One-cycle pulse qualifying host_rdata |
| host_rdata | output | 32 | Host read data |
| dn_req | output | 1 | Downstream request, held until dn_done |
| dn_addr | output | 32 | Downstream configuration address |
| dn_bytes | output | 3 | Downstream size in bytes (1, 2, 4) |
| dn_we | output | 1 | Downstream write flag |
| dn_wdata | output | 32 | Downstream write data |
| dn_rdata | input | 32 | Downstream read data, valid with dn_done |
| dn_done | input | 1 | Downstream completion |

## Verification
A corrupted address register shows at once on the port. It appears in the next `dn_addr` or address read-back, and a lost enable bit turns the next data access into an all-ones read with no request. A controller stuck busy leaves `host_ready` low and never pulses `host_rvalid`, so the next access stalls within a few cycles. The bench checks downstream address, size, write flag and data, together with the request count and the read-valid count, after every access. Both byte orders are covered by two instances that share the host stimulus.

// File: rtl/cfg_port_pkg.sv
// Package: shared size encoding and helpers for the configuration data bridge.
// Assumes host and downstream data paths are a whole number of bytes wide.
package cfg_port_pkg;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2,
        ACC_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } ctrl_state_e;

    // Number of bytes an access of size s moves, on a word of word_bytes bytes.
    function automatic int unsigned acc_bytes(acc_size_e s, int unsigned word_bytes);
        case (s)
            ACC_BYTE: acc_bytes = 1;
            ACC_HALF: acc_bytes = 2;
            default:  acc_bytes = word_bytes;
        endcase
    endfunction

endpackage

// File: rtl/cfg_addr_reg.sv
// Module: holds the stored configuration address; its top enable bit gates the window.
// Assumes writes arrive only while the controller is idle.
module cfg_addr_reg #(
    parameter int ADDR_W = 32,
    parameter int EN_BIT = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_val,
    input  logic              busy,
    output logic [ADDR_W-1:0] cfg_q,
    output logic              enable
);

    // Load the full address on an accepted register write; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q <= wr_val;
        end
    end

    assign enable = cfg_q[EN_BIT];

    AST_CFG_STABLE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cfg_q)); // R10

endmodule

// File: rtl/cfg_lane_fmt.sv
// Module: zero-extends data to the access size and optionally reverses byte order.
// Assumes the data width is a whole number of bytes; byte accesses never reorder.
module cfg_lane_fmt
    import cfg_port_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter bit BIG_ENDIAN = 1'b0
) (
    input  acc_size_e         size,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    localparam int NB = DATA_W / 8;

    int unsigned nb;
    assign nb = acc_bytes(size, NB);

    generate
        if (BIG_ENDIAN) begin : g_swap
            // Keep the low nb bytes in reversed order, zero the rest.
            always_comb begin
                dout = '0;
                for (int i = 0; i < NB; i++) begin
                    if (i < int'(nb)) begin
                        dout[i*8 +: 8] = din[(int'(nb) - 1 - i)*8 +: 8];
                    end
                end
            end
        end else begin : g_pass
            // Keep the low nb bytes in place, zero the rest.
            always_comb begin
                dout = '0;
                for (int i = 0; i < NB; i++) begin
                    if (i < int'(nb)) begin
                        dout[i*8 +: 8] = din[i*8 +: 8];
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/cfg_txn_ctrl.sv
// Module: decodes host strobes, issues one downstream transaction at a time
// and produces host read responses (register, disabled default, or downstream).
// Assumes dn_done arrives only while dn_req is high.
module cfg_txn_ctrl
    import cfg_port_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 2,
    parameter int BYTE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic [OFS_W-1:0]  host_ofs,
    input  acc_size_e         host_size,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] wdata_fmt,
    input  logic [ADDR_W-1:0] cfg_q,
    input  logic              enable,
    input  logic [DATA_W-1:0] rdata_fmt,
    input  logic              dn_done,
    output logic              host_ready,
    output logic              host_rvalid,
    output logic [DATA_W-1:0] host_rdata,
    output logic              reg_wr,
    output logic              busy,
    output logic              dn_req,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [BYTE_W-1:0] dn_bytes,
    output acc_size_e         dn_size,
    output logic              dn_we,
    output logic [DATA_W-1:0] dn_wdata
);

    localparam int NB = DATA_W / 8;

    ctrl_state_e       state_q;
    acc_size_e         size_n;
    logic              accept, dat_wr, dat_rd, reg_rd;
    logic [ADDR_W-1:0] merged_addr;
    logic [DATA_W-1:0] ones_val;

    assign host_ready = (state_q == ST_IDLE);
    assign busy       = (state_q == ST_BUSY);
    assign accept     = host_ready && (host_rd || host_wr);
    assign reg_wr     = accept && host_wr && host_sel;
    assign reg_rd     = accept && !host_wr && host_sel;
    assign dat_wr     = accept && host_wr && !host_sel;
    assign dat_rd     = accept && !host_wr && !host_sel;
    assign size_n     = (host_size == ACC_RSVD) ? ACC_WORD : host_size;

    // Downstream address: word writes keep the stored address, all else merge the offset.
    always_comb begin
        if (dat_wr && size_n == ACC_WORD) begin
            merged_addr = cfg_q;
        end else begin
            merged_addr = cfg_q | {{(ADDR_W-OFS_W){1'b0}}, host_ofs};
        end
    end

    // All-ones default for a disabled read, sized to the access.
    always_comb begin
        ones_val = '0;
        for (int i = 0; i < NB; i++) begin
            if (i < int'(acc_bytes(size_n, NB))) begin
                ones_val[i*8 +: 8] = 8'hFF;
            end
        end
    end

    // Transaction sequencing and host response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            dn_req      <= 1'b0;
            dn_addr     <= '0;
            dn_bytes    <= '0;
            dn_size     <= ACC_BYTE;
            dn_we       <= 1'b0;
            dn_wdata    <= '0;
            host_rvalid <= 1'b0;
            host_rdata  <= '0;
        end else begin
            host_rvalid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if ((dat_wr || dat_rd) && enable) begin
                        state_q  <= ST_BUSY;
                        dn_req   <= 1'b1;
                        dn_addr  <= merged_addr;
                        dn_bytes <= BYTE_W'(acc_bytes(size_n, NB));
                        dn_size  <= size_n;
                        dn_we    <= dat_wr;
                        dn_wdata <= dat_wr ? wdata_fmt : '0;
                    end else if (dat_rd) begin
                        host_rvalid <= 1'b1;
                        host_rdata  <= ones_val;
                    end else if (reg_rd) begin
                        host_rvalid <= 1'b1;
                        host_rdata  <= DATA_W'(cfg_q);
                    end
                end
                default: begin
                    if (dn_done) begin
                        state_q <= ST_IDLE;
                        dn_req  <= 1'b0;
                        if (!dn_we) begin
                            host_rvalid <= 1'b1;
                            host_rdata  <= rdata_fmt;
                        end
                    end
                end
            endcase
        end
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && !dn_done) |=> dn_req); // R10
    AST_RVALID_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> !dn_req); // R10
    AST_BYTES_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req |-> (dn_bytes == 1 || dn_bytes == 2 || dn_bytes == BYTE_W'(NB))); // R7
    AST_REQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dn_req) |-> $past(enable)); // R3

endmodule

// File: rtl/cfg_data_bridge.sv
// Module: top of the configuration data window bridge. Wires the address
// register, the transaction controller and the two byte-lane formatters.
// Assumes the downstream side answers each request with one dn_done pulse.
module cfg_data_bridge
    import cfg_port_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 32,
    parameter int EN_BIT     = 31,
    parameter int OFS_W      = 2,
    parameter bit BIG_ENDIAN = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic [OFS_W-1:0]  host_ofs,
    input  logic [1:0]        host_size,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ready,
    output logic              host_rvalid,
    output logic [DATA_W-1:0] host_rdata,
    output logic              dn_req,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [$clog2(DATA_W/8):0] dn_bytes,
    output logic              dn_we,
    output logic [DATA_W-1:0] dn_wdata,
    input  logic [DATA_W-1:0] dn_rdata,
    input  logic              dn_done
);

    localparam int BYTE_W = $clog2(DATA_W/8) + 1;

    acc_size_e         hsize, dsize;
    logic              reg_wr, enable, busy;
    logic [ADDR_W-1:0] cfg_q;
    logic [DATA_W-1:0] wdata_fmt, rdata_fmt;

    assign hsize = acc_size_e'(host_size);

    cfg_addr_reg #(.ADDR_W(ADDR_W), .EN_BIT(EN_BIT)) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr),
        .wr_val (ADDR_W'(host_wdata)),
        .busy   (busy),
        .cfg_q  (cfg_q),
        .enable (enable)
    );

    cfg_lane_fmt #(.DATA_W(DATA_W), .BIG_ENDIAN(BIG_ENDIAN)) u_wfmt (
        .size (hsize == ACC_RSVD ? ACC_WORD : hsize),
        .din  (host_wdata),
        .dout (wdata_fmt)
    );

    cfg_lane_fmt #(.DATA_W(DATA_W), .BIG_ENDIAN(BIG_ENDIAN)) u_rfmt (
        .size (dsize),
        .din  (dn_rdata),
        .dout (rdata_fmt)
    );

    cfg_txn_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFS_W(OFS_W), .BYTE_W(BYTE_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_sel    (host_sel),
        .host_ofs    (host_ofs),
        .host_size   (hsize),
        .host_rd     (host_rd),
        .host_wr     (host_wr),
        .wdata_fmt   (wdata_fmt),
        .cfg_q       (cfg_q),
        .enable      (enable),
        .rdata_fmt   (rdata_fmt),
        .dn_done     (dn_done),
        .host_ready  (host_ready),
        .host_rvalid (host_rvalid),
        .host_rdata  (host_rdata),
        .reg_wr      (reg_wr),
        .busy        (busy),
        .dn_req      (dn_req),
        .dn_addr     (dn_addr),
        .dn_bytes    (dn_bytes),
        .dn_size     (dsize),
        .dn_we       (dn_we),
        .dn_wdata    (dn_wdata)
    );

    AST_DISABLED_READ_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ready && host_rd && !host_wr && !host_sel && !enable) |=> !dn_req); // R4

endmodule

// File: tb/test_cfg_data_bridge.sv
// Downstream responder: answers each request two cycles later with data derived from the address.
module cfg_dn_model (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic [31:0] addr,
    input  logic [2:0]  bytes,
    input  logic        we,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        done,
    output logic [31:0] last_addr,
    output logic [2:0]  last_bytes,
    output logic        last_we,
    output logic [31:0] last_wdata,
    output int          req_cnt
);
    logic wait_q;
    always @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0; wait_q <= 1'b0; rdata <= '0; req_cnt <= 0;
            last_addr <= '0; last_bytes <= '0; last_we <= 1'b0; last_wdata <= '0;
        end else begin
            done <= 1'b0;
            if (req && !done) begin
                if (wait_q) begin
                    done <= 1'b1; wait_q <= 1'b0;
                    rdata <= {addr[7:0] ^ 8'hC3, addr[15:8], 8'h96, addr[7:0] ^ 8'h5A};
                    last_addr <= addr; last_bytes <= bytes; last_we <= we; last_wdata <= wdata;
                    req_cnt <= req_cnt + 1;
                end else begin
                    wait_q <= 1'b1;
                end
            end
        end
    end
endmodule

module test_cfg_data_bridge;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        h_sel = 0, h_rd = 0, h_wr = 0;
    logic [1:0]  h_ofs = 0, h_size = 0;
    logic [31:0] h_wdata = 0;

    logic        rdy_le, rv_le, req_le, we_le, done_le;
    logic [31:0] rd_le, addr_le, wd_le, dr_le;
    logic [2:0]  by_le;
    logic        rdy_be, rv_be, req_be, we_be, done_be;
    logic [31:0] rd_be, addr_be, wd_be, dr_be;
    logic [2:0]  by_be;

    logic [31:0] la_le, lw_le, la_be, lw_be;
    logic [2:0]  lb_le, lb_be;
    logic        lwe_le, lwe_be;
    int          rc_le, rc_be;

    cfg_data_bridge #(.BIG_ENDIAN(1'b0)) i_cfg_data_bridge (
        .clk(clk), .rst_n(rst_n), .host_sel(h_sel), .host_ofs(h_ofs), .host_size(h_size),
        .host_rd(h_rd), .host_wr(h_wr), .host_wdata(h_wdata), .host_ready(rdy_le),
        .host_rvalid(rv_le), .host_rdata(rd_le), .dn_req(req_le), .dn_addr(addr_le),
        .dn_bytes(by_le), .dn_we(we_le), .dn_wdata(wd_le), .dn_rdata(dr_le), .dn_done(done_le));

    cfg_data_bridge #(.BIG_ENDIAN(1'b1)) i_cfg_data_bridge_be (
        .clk(clk), .rst_n(rst_n), .host_sel(h_sel), .host_ofs(h_ofs), .host_size(h_size),
        .host_rd(h_rd), .host_wr(h_wr), .host_wdata(h_wdata), .host_ready(rdy_be),
        .host_rvalid(rv_be), .host_rdata(rd_be), .dn_req(req_be), .dn_addr(addr_be),
        .dn_bytes(by_be), .dn_we(we_be), .dn_wdata(wd_be), .dn_rdata(dr_be), .dn_done(done_be));

    cfg_dn_model u_m_le (.clk(clk), .rst_n(rst_n), .req(req_le), .addr(addr_le), .bytes(by_le),
        .we(we_le), .wdata(wd_le), .rdata(dr_le), .done(done_le), .last_addr(la_le),
        .last_bytes(lb_le), .last_we(lwe_le), .last_wdata(lw_le), .req_cnt(rc_le));
    cfg_dn_model u_m_be (.clk(clk), .rst_n(rst_n), .req(req_be), .addr(addr_be), .bytes(by_be),
        .we(we_be), .wdata(wd_be), .rdata(dr_be), .done(done_be), .last_addr(la_be),
        .last_bytes(lb_be), .last_we(lwe_be), .last_wdata(lw_be), .req_cnt(rc_be));

    int n_tests = 0, n_fail = 0, cycles = 0;
    int rvc_le = 0, rvc_be = 0;
    logic [31:0] cap_le = 0, cap_be = 0;

    // Capture host read responses away from the clock edge.
    always @(negedge clk) begin
        if (rv_le) begin cap_le = rd_le; rvc_le++; end
        if (rv_be) begin cap_be = rd_be; rvc_be++; end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: act=%0d cycles exp<20000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Size-format a value as the requirements state: low bytes kept, optional reversal.
    function automatic logic [31:0] fmt(input logic [31:0] d, input logic [1:0] sz, input bit be);
        case (sz)
            2'd0:    fmt = {24'h0, d[7:0]};
            2'd1:    fmt = be ? {16'h0, d[7:0], d[15:8]} : {16'h0, d[15:0]};
            default: fmt = be ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d;
        endcase
    endfunction

    function automatic logic [31:0] model_data(input logic [31:0] a);
        model_data = {a[7:0] ^ 8'hC3, a[15:8], 8'h96, a[7:0] ^ 8'h5A};
    endfunction

    task automatic wait_idle();
        @(negedge clk);
        while (!(rdy_le && rdy_be)) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic access(input bit sel, input bit wr, input logic [1:0] sz,
                          input logic [1:0] ofs, input logic [31:0] wd);
        @(negedge clk);
        h_sel = sel; h_wr = wr; h_rd = !wr; h_size = sz; h_ofs = ofs; h_wdata = wd;
        @(negedge clk);
        h_wr = 0; h_rd = 0;
        wait_idle();
    endtask

    // Vector: {write, size[1:0], ofs[1:0], wdata[31:0]}
    localparam logic [36:0] VEC [0:8] = '{
        {1'b1, 2'd0, 2'd2, 32'hDEADBE5A},
        {1'b1, 2'd1, 2'd1, 32'h1234ABCD},
        {1'b1, 2'd2, 2'd3, 32'h11223344},
        {1'b1, 2'd1, 2'd0, 32'hFFFF0F1E},
        {1'b0, 2'd0, 2'd3, 32'h0},
        {1'b0, 2'd1, 2'd2, 32'h0},
        {1'b0, 2'd2, 2'd1, 32'h0},
        {1'b0, 2'd2, 2'd2, 32'h0},
        {1'b0, 2'd3, 2'd2, 32'h0}
    };

    localparam logic [31:0] CFG_ON = 32'h8012_3401;

    initial begin
        int r0, q0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(rdy_le && rdy_be, "R1 ready after reset", {31'b0, rdy_le}, 32'h1);
        chk(!req_le && !req_be, "R1 no request after reset", {31'b0, req_le}, 32'h0);
        chk(!rv_le && !rv_be, "R1 no rvalid after reset", {31'b0, rv_le}, 32'h0);
        q0 = rvc_le;
        access(1, 0, 2'd2, 2'd0, 32'h0);
        chk(cap_le == 32'h0 && rvc_le == q0 + 1, "R1 address register resets to 0", cap_le, 32'h0);

        // R2/R3/R4: disabled window
        access(1, 1, 2'd2, 2'd0, 32'h0000_1A01);
        access(1, 0, 2'd2, 2'd0, 32'h0);
        chk(cap_le == 32'h0000_1A01 && cap_be == 32'h0000_1A01, "R2 address readback", cap_le, 32'h0000_1A01);
        r0 = rc_le;
        access(0, 1, 2'd2, 2'd0, 32'hCAFEF00D);
        access(0, 1, 2'd0, 2'd1, 32'h000000AA);
        chk(rc_le == r0 && rc_be == r0, "R3 disabled write issues no request", rc_le, r0);
        for (int s = 0; s < 3; s++) begin
            logic [31:0] ev;
            ev = (s == 0) ? 32'hFF : (s == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
            q0 = rvc_le;
            access(0, 0, 2'(s), 2'd2, 32'h0);
            chk(cap_le == ev && cap_be == ev && rvc_le == q0 + 1, "R4 disabled read all-ones", cap_le, ev);
        end
        chk(rc_le == r0 && rc_be == r0, "R4 disabled read issues no request", rc_le, r0);

        // Enable window
        access(1, 1, 2'd2, 2'd0, CFG_ON);
        access(1, 0, 2'd2, 2'd0, 32'h0);
        chk(cap_le == CFG_ON && cap_be == CFG_ON, "R2 enabled address readback", cap_le, CFG_ON);

        // Table walk: R5 R6 R7 R8 R9
        for (int v = 0; v < 9; v++) begin
            logic wr; logic [1:0] sz, ofs; logic [31:0] wd, ea; logic [2:0] eb;
            int rb, qb;
            wr = VEC[v][36]; sz = VEC[v][35:34]; ofs = VEC[v][33:32]; wd = VEC[v][31:0];
            ea = (wr && sz >= 2) ? CFG_ON : (CFG_ON | {30'b0, ofs});
            eb = (sz == 0) ? 3'd1 : (sz == 1) ? 3'd2 : 3'd4;
            rb = rc_le; qb = rvc_le;
            access(0, wr, sz, ofs, wd);
            chk(rc_le == rb + 1 && rc_be == rb + 1, "R10 one request per access", rc_le, rb + 1);
            chk(la_le == ea && la_be == ea, (wr && sz >= 2) ? "R6 word write address" : "R5 merged address", la_le, ea);
            chk(lb_le == eb && lb_be == eb && lwe_le == wr, "R7 size and write flag", {29'b0, lb_le}, {29'b0, eb});
            if (wr) begin
                chk(lw_le == fmt(wd, sz, 0), "R8 write data little-endian", lw_le, fmt(wd, sz, 0));
                chk(lw_be == fmt(wd, sz, 1), "R8 write data big-endian", lw_be, fmt(wd, sz, 1));
                chk(rvc_le == qb, "R10 no rvalid on write", rvc_le, qb);
            end else begin
                chk(cap_le == fmt(model_data(ea), sz, 0) && rvc_le == qb + 1, "R9 read data little-endian",
                    cap_le, fmt(model_data(ea), sz, 0));
                chk(cap_be == fmt(model_data(ea), sz, 1), "R9 read data big-endian",
                    cap_be, fmt(model_data(ea), sz, 1));
            end
        end

        // R10: strobes while busy are ignored; request held.
        @(negedge clk);
        h_sel = 0; h_rd = 1; h_wr = 0; h_size = 2'd2; h_ofs = 2'd0;
        @(negedge clk);
        h_rd = 0;
        chk(!rdy_le && req_le && req_be, "R10 busy with request held", {31'b0, rdy_le}, 32'h0);
        h_sel = 1; h_wr = 1; h_wdata = 32'h0;
        @(negedge clk);
        chk(req_le && !rdy_le, "R10 request held until done", {31'b0, req_le}, 32'h1);
        h_wr = 0; h_sel = 0;
        wait_idle();
        access(1, 0, 2'd2, 2'd0, 32'h0);
        chk(cap_le == CFG_ON && cap_be == CFG_ON, "R10 write during busy ignored", cap_le, CFG_ON);

        // R1: reset mid-run clears the address register
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk); rst_n = 1;
        access(1, 0, 2'd2, 2'd0, 32'h0);
        chk(cap_le == 32'h0 && cap_be == 32'h0, "R1 reset clears address", cap_le, 32'h0);
        access(0, 0, 2'd2, 2'd0, 32'h0);
        chk(cap_le == 32'hFFFF_FFFF, "R1 disabled after reset", cap_le, 32'hFFFF_FFFF);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule